// File: doc/BRIEF.md
# DQS Receive-Enable Training Sequencer

This block runs the hardware-assisted receive-enable training flow of a DDR memory controller. When it is started it walks every memory channel and, inside each channel, every chip select in ascending order, passing over chip selects that the population map marks as absent. For each populated chip select it opens a training window. It raises the training-enable strobe and asks an external read generator to start a stream of back-to-back reads. It then holds the window open for a fixed number of memory clocks, closes it, and asks an external combiner to turn the phase-recovery result into final delays. A chip select with an even number first selects its DIMM and asks an external seed engine to preload the seeds for that DIMM. The odd partner of the pair reuses those seeds.

At the end of each channel the sequencer asks an external search engine for the largest trained delay. If a maximum was found, it requests a max read latency update. In every case it then requests a write-pointer reset with a fixed value. All partners use a request/acknowledge handshake. The second training pass is skipped, and reported as a success, when the operating speed is not above the start-up speed. A full run reports failure when the accumulated error state is fatal.

Top module: `rxen_train_seq`

## Requirements
- R1: During and after reset `busy_o`, `done_o`, `train_en_o` and every request output are low, and they stay low while the block is idle.
- R2: Channels are visited in ascending order and, inside a channel, chip selects 0 to CS_PER_CH-1 in ascending order. A chip select whose population bit `pop_map_i[ch*CS_PER_CH+cs]` is 0 produces no seed, read or combine request. `ch_o` and `cs_o` name the chip select being trained while its requests are raised.
- R3: A seed request is raised only for a populated chip select with an even number. It comes before that chip select's read request, and while it is raised `dimm_sel_o` equals `cs_o >> 1`.
- R4: `train_en_o` rises no later than the read request and stays high for as long as `rd_req_o` is high.
- R5: After the cycle in which `rd_ack_i` is accepted, `train_en_o` stays high for exactly WAIT_CLKS cycles (default 200). It then falls in the same cycle in which the combine request rises.
- R6: After the last chip select of a channel, the search request is raised. The latency request follows only if `find_ok_i` was 1 with the search acknowledge. The write-pointer reset request is raised last, with `wrp_val_o` = 6.
- R7: With `pass2_i` = 1 and `speed_cur_i` <= `speed_boot_i`, a start raises no request. `done_o` is high in the cycle right after the start is sampled, with `ok_o` = 1. With `speed_cur_i` > `speed_boot_i`, pass 2 trains normally.
- R8: At the end of a full run `ok_o` equals the inverse of `err_fatal_i` as sampled with the last write-pointer acknowledge, and it is valid while `done_o` is high.
- R9: `busy_o` stays high from the cycle after an accepted start through the single `done_o` cycle. A start that arrives while busy is ignored.
- R10: At most one request is high at a time. Each request is held until its acknowledge is seen, and an acknowledge whose request is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one training pass (sampled when idle) |
| pass2_i | input | 1 | 0 = first pass, 1 = second pass |
| speed_cur_i | input | SPD_W | Current operating speed code |
| speed_boot_i | input | SPD_W | Start-up speed code |
| pop_map_i | input | NUM_CH*CS_PER_CH | Chip select population, bit ch*CS_PER_CH+cs |
| err_fatal_i | input | 1 | Accumulated error state is fatal or worse |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Pass result, valid with done_o |
| ch_o | output | CH_W | Channel being trained |
| cs_o | output | CS_W | Chip select being trained |
| dimm_sel_o | output | CS_W-1 | Selected DIMM for seeding |
| train_en_o | output | 1 | Receive-enable training strobe |
| seed_req_o | output | 1 | Seed preparation request |
| seed_ack_i | input | 1 | Seed preparation done |
| rd_req_o | output | 1 | Back-to-back read stream request |
| rd_ack_i | input | 1 | Read stream started |
| comb_req_o | output | 1 | Final delay combine request |
| comb_ack_i | input | 1 | Combine done |
| find_req_o | output | 1 | Max delay search request |
| find_ack_i | input | 1 | Search done |
| find_ok_i | input | 1 | Search found a maximum (with find_ack_i) |
| lat_req_o | output | 1 | Max read latency update request |
| lat_ack_i | input | 1 | Latency update done |
| wrp_req_o | output | 1 | Write-pointer reset request |
| wrp_val_o | output | WRP_W | Write-pointer reset value |
| wrp_ack_i | input | 1 | Write-pointer reset done |

## Verification
Two things can land in the same cycle: the timed training window counting down, and partner acknowledges or a fresh start pulse that belong to no open request. The bench provokes this by driving every acknowledge at once, and pulsing start, while the window is open and no request is high. The judgement is that the window still lasts exactly WAIT_CLKS cycles, that the logged request order matches the one predicted from the population map, and that busy never drops and done arrives only once.

// File: rtl/rxen_pkg.sv
// Package: shared types of the receive-enable training sequencer.
// Assumes: nothing; holds only the control state encoding.
package rxen_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SEED,
        ST_READ,
        ST_WAIT,
        ST_COMB,
        ST_FIND,
        ST_LAT,
        ST_WRP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/rxen_cursor.sv
// Module: rxen_cursor
// Holds the current channel and chip select of the training walk, and looks
// up whether that chip select is populated and whether it or its channel is
// the last one.
// Assumes: clr_i, next_cs_i and next_ch_i are mutually exclusive; next_ch_i
// also rewinds the chip select to 0.
module rxen_cursor #(
    parameter int NUM_CH    = 2,
    parameter int CS_PER_CH = 8,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CS_W     = (CS_PER_CH > 1) ? $clog2(CS_PER_CH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        next_cs_i,
    input  logic                        next_ch_i,
    input  logic [NUM_CH*CS_PER_CH-1:0] pop_map_i,
    output logic [CH_W-1:0]             ch_o,
    output logic [CS_W-1:0]             cs_o,
    output logic                        cs_pop_o,
    output logic                        cs_last_o,
    output logic                        ch_last_o
);

    logic [CH_W-1:0]      ch_q;
    logic [CS_W-1:0]      cs_q;
    logic [CS_PER_CH-1:0] row [NUM_CH];

    // Split the flat population map into one row per channel.
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_row
            assign row[g] = pop_map_i[g*CS_PER_CH +: CS_PER_CH];
        end
    endgenerate

    // Advance or rewind the channel / chip select position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
            cs_q <= '0;
        end else if (clr_i) begin
            ch_q <= '0;
            cs_q <= '0;
        end else if (next_ch_i) begin
            ch_q <= ch_q + CH_W'(1);
            cs_q <= '0;
        end else if (next_cs_i) begin
            cs_q <= cs_q + CS_W'(1);
        end
    end

    // Look up population and end-of-range flags for the current position.
    always_comb begin
        cs_pop_o  = row[ch_q][cs_q];
        cs_last_o = (cs_q == CS_W'(CS_PER_CH - 1));
        ch_last_o = (ch_q == CH_W'(NUM_CH - 1));
    end

    assign ch_o = ch_q;
    assign cs_o = cs_q;

endmodule

// File: rtl/rxen_win_timer.sv
// Module: rxen_win_timer
// Counts the training window in memory clocks. arm_i clears the count.
// While run_i is high the count advances, and expire_o marks the last
// window cycle.
// Assumes: WAIT_CLKS >= 1; run_i stays high until expire_o is seen.
module rxen_win_timer #(
    parameter int WAIT_CLKS = 200,
    localparam int CNT_W    = $clog2(WAIT_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic run_i,
    output logic expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Clear on arm, count while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Flag the final cycle of the window.
    assign expire_o = run_i && (cnt_q == CNT_W'(WAIT_CLKS - 1));

endmodule

// File: rtl/rxen_pass_gate.sv
// Module: rxen_pass_gate
// Decides whether a requested pass is skipped: the second pass runs only
// when the operating speed is above the start-up speed.
// Assumes: speed codes grow monotonically with frequency.
module rxen_pass_gate #(
    parameter int SPD_W = 8
) (
    input  logic             pass2_i,
    input  logic [SPD_W-1:0] speed_cur_i,
    input  logic [SPD_W-1:0] speed_boot_i,
    output logic             skip_o
);

    // Skip pass 2 unless the speed has risen.
    always_comb begin
        skip_o = pass2_i && !(speed_cur_i > speed_boot_i);
    end

endmodule

// File: rtl/rxen_train_seq.sv
// Module: rxen_train_seq
// Top of the receive-enable training sequencer. It walks channels and chip
// selects, seeds on even chip selects, brackets a timed read burst with the
// training strobe, asks for the final delay combine, and closes each channel
// with a max delay search, an optional latency update and a write-pointer
// reset.
// Assumes: partners pulse their acknowledge for one cycle once work is done;
// find_ok_i is valid together with find_ack_i; err_fatal_i is valid with the
// last write-pointer acknowledge.
module rxen_train_seq
    import rxen_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CS_PER_CH = 8,
    parameter int SPD_W     = 8,
    parameter int WAIT_CLKS = 200,
    parameter int WRP_W     = 3,
    parameter int WRP_VAL   = 6,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CS_W     = (CS_PER_CH > 1) ? $clog2(CS_PER_CH) : 1,
    localparam int DIMM_W   = (CS_W > 1) ? CS_W - 1 : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        pass2_i,
    input  logic [SPD_W-1:0]            speed_cur_i,
    input  logic [SPD_W-1:0]            speed_boot_i,
    input  logic [NUM_CH*CS_PER_CH-1:0] pop_map_i,
    input  logic                        err_fatal_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        ok_o,
    output logic [CH_W-1:0]             ch_o,
    output logic [CS_W-1:0]             cs_o,
    output logic [DIMM_W-1:0]           dimm_sel_o,
    output logic                        train_en_o,
    output logic                        seed_req_o,
    input  logic                        seed_ack_i,
    output logic                        rd_req_o,
    input  logic                        rd_ack_i,
    output logic                        comb_req_o,
    input  logic                        comb_ack_i,
    output logic                        find_req_o,
    input  logic                        find_ack_i,
    input  logic                        find_ok_i,
    output logic                        lat_req_o,
    input  logic                        lat_ack_i,
    output logic                        wrp_req_o,
    output logic [WRP_W-1:0]            wrp_val_o,
    input  logic                        wrp_ack_i
);

    seq_state_e        state_q;
    logic              train_en_q;
    logic [DIMM_W-1:0] dimm_q;
    logic              ok_q;

    logic              skip;
    logic              cs_pop;
    logic              cs_last;
    logic              ch_last;
    logic              cur_clr;
    logic              cur_next_cs;
    logic              cur_next_ch;
    logic              win_arm;
    logic              win_run;
    logic              win_expire;
    logic [CS_W-1:0]   cs_cur;

    rxen_pass_gate #(
        .SPD_W        (SPD_W)
    ) u_gate (
        .pass2_i      (pass2_i),
        .speed_cur_i  (speed_cur_i),
        .speed_boot_i (speed_boot_i),
        .skip_o       (skip)
    );

    rxen_cursor #(
        .NUM_CH    (NUM_CH),
        .CS_PER_CH (CS_PER_CH)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cur_clr),
        .next_cs_i (cur_next_cs),
        .next_ch_i (cur_next_ch),
        .pop_map_i (pop_map_i),
        .ch_o      (ch_o),
        .cs_o      (cs_cur),
        .cs_pop_o  (cs_pop),
        .cs_last_o (cs_last),
        .ch_last_o (ch_last)
    );

    rxen_win_timer #(
        .WAIT_CLKS (WAIT_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (win_arm),
        .run_i     (win_run),
        .expire_o  (win_expire)
    );

    // Cursor and timer controls decoded from the state and the handshakes.
    always_comb begin
        cur_clr     = (state_q == ST_IDLE) && start_i;
        cur_next_cs = ((state_q == ST_SCAN) && !cs_pop && !cs_last) ||
                      ((state_q == ST_COMB) && comb_ack_i && !cs_last);
        cur_next_ch = (state_q == ST_WRP) && wrp_ack_i && !ch_last;
        win_arm     = (state_q == ST_READ) && rd_ack_i;
        win_run     = (state_q == ST_WAIT);
    end

    // Main training flow: state, strobe, DIMM select and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            train_en_q <= 1'b0;
            dimm_q     <= '0;
            ok_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (skip) begin
                            ok_q    <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            ok_q    <= 1'b0;
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (cs_pop) begin
                        if (!cs_cur[0]) begin
                            dimm_q  <= DIMM_W'(cs_cur >> 1);
                            state_q <= ST_SEED;
                        end else begin
                            train_en_q <= 1'b1;
                            state_q    <= ST_READ;
                        end
                    end else if (cs_last) begin
                        state_q <= ST_FIND;
                    end
                end
                ST_SEED: begin
                    if (seed_ack_i) begin
                        train_en_q <= 1'b1;
                        state_q    <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack_i) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (win_expire) begin
                        train_en_q <= 1'b0;
                        state_q    <= ST_COMB;
                    end
                end
                ST_COMB: begin
                    if (comb_ack_i) begin
                        state_q <= cs_last ? ST_FIND : ST_SCAN;
                    end
                end
                ST_FIND: begin
                    if (find_ack_i) begin
                        state_q <= find_ok_i ? ST_LAT : ST_WRP;
                    end
                end
                ST_LAT: begin
                    if (lat_ack_i) begin
                        state_q <= ST_WRP;
                    end
                end
                ST_WRP: begin
                    if (wrp_ack_i) begin
                        if (ch_last) begin
                            ok_q    <= !err_fatal_i;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Request and status outputs decoded from the state.
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        seed_req_o = (state_q == ST_SEED);
        rd_req_o   = (state_q == ST_READ);
        comb_req_o = (state_q == ST_COMB);
        find_req_o = (state_q == ST_FIND);
        lat_req_o  = (state_q == ST_LAT);
        wrp_req_o  = (state_q == ST_WRP);
    end

    assign ok_o       = ok_q;
    assign cs_o       = cs_cur;
    assign dimm_sel_o = dimm_q;
    assign train_en_o = train_en_q;
    assign wrp_val_o  = WRP_W'(WRP_VAL);

endmodule

// File: rtl/rxen_train_seq_chk.sv
// Module: rxen_train_seq_chk
// Protocol checker for rxen_train_seq, attached by bind. It watches only
// the ports of the sequencer.
// Assumes: clk and rst_n are the sequencer's own.
module rxen_train_seq_chk #(
    parameter int CS_W   = 3,
    parameter int DIMM_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              train_en_o,
    input logic [CS_W-1:0]   cs_o,
    input logic [DIMM_W-1:0] dimm_sel_o,
    input logic              seed_req_o,
    input logic              seed_ack_i,
    input logic              rd_req_o,
    input logic              rd_ack_i,
    input logic              comb_req_o,
    input logic              comb_ack_i,
    input logic              find_req_o,
    input logic              find_ack_i,
    input logic              lat_req_o,
    input logic              lat_ack_i,
    input logic              wrp_req_o,
    input logic              wrp_ack_i
);

    logic [5:0] reqs;
    assign reqs = {wrp_req_o, lat_req_o, find_req_o, comb_req_o, rd_req_o, seed_req_o};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (reqs == 6'b0) && !train_en_o);

    p_seed_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_req_o |-> !cs_o[0] && (dimm_sel_o == DIMM_W'(cs_o >> 1)));

    p_rd_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> train_en_o);

    p_comb_closes_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comb_req_o) |-> $fell(train_en_o));

    p_lat_after_find_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_req_o) |-> $past(find_req_o));

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    p_hold_seed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seed_req_o && !seed_ack_i |=> seed_req_o);

    p_hold_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o);

    p_hold_comb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        comb_req_o && !comb_ack_i |=> comb_req_o);

    p_hold_find_r10: assert property (@(posedge clk) disable iff (!rst_n)
        find_req_o && !find_ack_i |=> find_req_o);

    p_hold_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lat_req_o && !lat_ack_i |=> lat_req_o);

    p_hold_wrp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrp_req_o && !wrp_ack_i |=> wrp_req_o);

endmodule

bind rxen_train_seq rxen_train_seq_chk #(
    .CS_W   (CS_W),
    .DIMM_W (DIMM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .train_en_o (train_en_o),
    .cs_o       (cs_o),
    .dimm_sel_o (dimm_sel_o),
    .seed_req_o (seed_req_o),
    .seed_ack_i (seed_ack_i),
    .rd_req_o   (rd_req_o),
    .rd_ack_i   (rd_ack_i),
    .comb_req_o (comb_req_o),
    .comb_ack_i (comb_ack_i),
    .find_req_o (find_req_o),
    .find_ack_i (find_ack_i),
    .lat_req_o  (lat_req_o),
    .lat_ack_i  (lat_ack_i),
    .wrp_req_o  (wrp_req_o),
    .wrp_ack_i  (wrp_ack_i)
);

// File: tb/test_rxen_train_seq.sv
// Directed bench for rxen_train_seq: an automatic partner model acknowledges
// every request and logs it, and each scenario task checks its own results.
module test_rxen_train_seq;

    localparam int NCH   = 2;
    localparam int NCS   = 8;
    localparam int WAITC = 200;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            start_i;
    logic            pass2_i;
    logic [7:0]      speed_cur_i;
    logic [7:0]      speed_boot_i;
    logic [NCH*NCS-1:0] pop_map_i;
    logic            err_fatal_i;
    logic            busy_o, done_o, ok_o;
    logic [0:0]      ch_o;
    logic [2:0]      cs_o;
    logic [1:0]      dimm_sel_o;
    logic            train_en_o;
    logic            seed_req_o, seed_ack_i;
    logic            rd_req_o, rd_ack_i;
    logic            comb_req_o, comb_ack_i;
    logic            find_req_o, find_ack_i, find_ok_i;
    logic            lat_req_o, lat_ack_i;
    logic            wrp_req_o, wrp_ack_i;
    logic [2:0]      wrp_val_o;

    rxen_train_seq i_rxen_train_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pass2_i      (pass2_i),
        .speed_cur_i  (speed_cur_i),
        .speed_boot_i (speed_boot_i),
        .pop_map_i    (pop_map_i),
        .err_fatal_i  (err_fatal_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ok_o         (ok_o),
        .ch_o         (ch_o),
        .cs_o         (cs_o),
        .dimm_sel_o   (dimm_sel_o),
        .train_en_o   (train_en_o),
        .seed_req_o   (seed_req_o),
        .seed_ack_i   (seed_ack_i),
        .rd_req_o     (rd_req_o),
        .rd_ack_i     (rd_ack_i),
        .comb_req_o   (comb_req_o),
        .comb_ack_i   (comb_ack_i),
        .find_req_o   (find_req_o),
        .find_ack_i   (find_ack_i),
        .find_ok_i    (find_ok_i),
        .lat_req_o    (lat_req_o),
        .lat_ack_i    (lat_ack_i),
        .wrp_req_o    (wrp_req_o),
        .wrp_val_o    (wrp_val_o),
        .wrp_ack_i    (wrp_ack_i)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Event log (1 seed, 2 read, 3 combine, 4 search, 5 latency, 6 wr-ptr).
    int lg_t [128];
    int lg_c [128];
    int lg_s [128];
    int lg_d [128];
    int lg_n;
    int ex_t [128];
    int ex_c [128];
    int ex_s [128];
    int ex_d [128];
    int ex_n;
    int win_min, win_max, win_n, win_cnt;
    bit win_arm;
    int wrp_bad;
    int busy_gap;
    bit in_run;
    bit stray_go;
    int ack_dly;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Partner model and monitor share one process so their order is fixed.
    initial begin
        logic [5:0] prev;
        logic [5:0] cur;
        bit ack_hi;
        int wcnt;
        prev = '0; ack_hi = 0; wcnt = 0;
        seed_ack_i = 0; rd_ack_i = 0; comb_ack_i = 0;
        find_ack_i = 0; lat_ack_i = 0; wrp_ack_i = 0;
        forever begin
            @(negedge clk);
            cur = {wrp_req_o, lat_req_o, find_req_o, comb_req_o, rd_req_o, seed_req_o};
            for (int k = 0; k < 6; k++) begin
                if (cur[k] && !prev[k] && lg_n < 128) begin
                    lg_t[lg_n] = k + 1;
                    lg_c[lg_n] = int'(ch_o);
                    lg_s[lg_n] = (k < 3) ? int'(cs_o) : 0;
                    lg_d[lg_n] = (k == 0) ? int'(dimm_sel_o) : 0;
                    lg_n++;
                    if (k == 5 && wrp_val_o != 3'd6) wrp_bad++;
                end
            end
            prev = cur;
            if (win_arm) begin
                if (train_en_o) win_cnt++;
                else begin
                    if (win_cnt < win_min) win_min = win_cnt;
                    if (win_cnt > win_max) win_max = win_cnt;
                    win_n++;
                    win_arm = 0;
                end
            end
            if (in_run && !busy_o) busy_gap++;
            if (ack_hi) begin
                seed_ack_i = 0; rd_ack_i = 0; comb_ack_i = 0;
                find_ack_i = 0; lat_ack_i = 0; wrp_ack_i = 0;
                ack_hi = 0; wcnt = 0;
            end else if (stray_go && cur == 6'b0 && busy_o && train_en_o) begin
                seed_ack_i = 1; rd_ack_i = 1; comb_ack_i = 1;
                find_ack_i = 1; lat_ack_i = 1; wrp_ack_i = 1;
                ack_hi = 1; stray_go = 0;
            end else if (cur != 6'b0) begin
                if (wcnt >= ack_dly) begin
                    seed_ack_i = cur[0]; rd_ack_i = cur[1]; comb_ack_i = cur[2];
                    find_ack_i = cur[3]; lat_ack_i = cur[4]; wrp_ack_i = cur[5];
                    ack_hi = 1;
                    if (cur[1]) begin win_arm = 1; win_cnt = 0; end
                end else wcnt++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic void add_exp(input int t, input int c, input int s, input int d);
        ex_t[ex_n] = t; ex_c[ex_n] = c; ex_s[ex_n] = s; ex_d[ex_n] = d;
        ex_n++;
    endfunction

    // Predict the request order from the population map and search result.
    function automatic void build_exp(input logic [NCH*NCS-1:0] m, input bit fok);
        ex_n = 0;
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NCS; s++) begin
                if (m[c*NCS+s]) begin
                    if (s % 2 == 0) add_exp(1, c, s, s / 2);
                    add_exp(2, c, s, 0);
                    add_exp(3, c, s, 0);
                end
            end
            add_exp(4, c, 0, 0);
            if (fok) add_exp(5, c, 0, 0);
            add_exp(6, c, 0, 0);
        end
    endfunction

    task automatic cmp_log(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            if (bad < 0 && (lg_t[i] != ex_t[i] || lg_c[i] != ex_c[i] ||
                            lg_s[i] != ex_s[i] || lg_d[i] != ex_d[i])) bad = i;
        end
        chk(lg_n == ex_n, {req, " event count"}, lg_n, ex_n);
        chk(bad < 0, {req, " first mismatching event index"}, bad, -1);
        if (bad >= 0)
            $display("  event %0d: got t%0d ch%0d cs%0d d%0d, want t%0d ch%0d cs%0d d%0d",
                     bad, lg_t[bad], lg_c[bad], lg_s[bad], lg_d[bad],
                     ex_t[bad], ex_c[bad], ex_s[bad], ex_d[bad]);
    endtask

    // Start one pass and wait for done; returns cycles from start to done.
    task automatic run_pass(input logic [NCH*NCS-1:0] m, input bit p2,
                            input logic [7:0] spd_cur, input logic [7:0] spd_boot,
                            input bit fok, input bit fatal, input bit stray,
                            output int cyc);
        lg_n = 0; win_n = 0; win_min = 1 << 30; win_max = 0; wrp_bad = 0;
        busy_gap = 0; win_arm = 0;
        pop_map_i = m; pass2_i = p2; speed_cur_i = spd_cur; speed_boot_i = spd_boot;
        find_ok_i = fok; err_fatal_i = fatal;
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        in_run = 1;
        cyc = 0;
        if (stray) stray_go = 1;
        while (!done_o) begin
            if (stray && cyc == 30) start_i = 1;
            if (stray && cyc == 31) start_i = 0;
            @(negedge clk);
            cyc++;
        end
        in_run = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; start_i = 0; pass2_i = 0; speed_cur_i = 0; speed_boot_i = 0;
        pop_map_i = '0; err_fatal_i = 0; find_ok_i = 0;
        lg_n = 0; ack_dly = 1; stray_go = 0; in_run = 0; win_arm = 0;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R1 busy/done in reset", int'({busy_o, done_o}), 0);
        chk(train_en_o == 0, "R1 strobe in reset", int'(train_en_o), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk({seed_req_o, rd_req_o, comb_req_o, find_req_o, lat_req_o, wrp_req_o} == 6'b0,
            "R1 requests idle after reset",
            int'({seed_req_o, rd_req_o, comb_req_o, find_req_o, lat_req_o, wrp_req_o}), 0);
        chk(busy_o == 0 && train_en_o == 0, "R1 idle after reset", int'({busy_o, train_en_o}), 0);
        chk(lg_n == 0, "R1 no events while idle", lg_n, 0);
    endtask

    task automatic t_full_population();
        int cyc;
        run_pass('1, 0, 8'd4, 8'd4, 1, 0, 0, cyc);
        chk(ok_o == 1, "R8 ok after clean full run", int'(ok_o), 1);
        build_exp('1, 1);
        cmp_log("R2 R3 R6 full population order");
        chk(win_n == NCH*NCS, "R5 window count", win_n, NCH*NCS);
        chk(win_min == WAITC && win_max == WAITC, "R5 window length", win_min, WAITC);
        chk(wrp_bad == 0, "R6 write-pointer value 6", wrp_bad, 0);
        chk(busy_gap == 0, "R9 busy held through run", busy_gap, 0);
    endtask

    task automatic t_sparse();
        int cyc;
        logic [NCH*NCS-1:0] m;
        m = 16'b0000_0000_0100_1110;
        ack_dly = 3;
        run_pass(m, 0, 8'd4, 8'd4, 0, 0, 0, cyc);
        build_exp(m, 0);
        cmp_log("R2 R3 R6 sparse map, no latency update");
        chk(win_min == WAITC && win_max == WAITC, "R5 window length with slow partners",
            win_max, WAITC);
        chk(ok_o == 1, "R8 ok sparse run", int'(ok_o), 1);
        ack_dly = 1;
    endtask

    task automatic t_pass2();
        int cyc;
        run_pass('1, 1, 8'd4, 8'd4, 1, 1, 0, cyc);
        chk(cyc == 0, "R7 skipped pass done next cycle", cyc, 0);
        chk(lg_n == 0, "R7 skipped pass raises no request", lg_n, 0);
        chk(ok_o == 1, "R7 skipped pass reports ok", int'(ok_o), 1);
        run_pass(16'h0300, 1, 8'd9, 8'd4, 1, 0, 0, cyc);
        build_exp(16'h0300, 1);
        cmp_log("R7 pass 2 runs when speed rose");
    endtask

    task automatic t_fatal();
        int cyc;
        run_pass(16'h0001, 0, 8'd4, 8'd4, 0, 1, 0, cyc);
        chk(ok_o == 0, "R8 fatal error reported", int'(ok_o), 0);
        build_exp(16'h0001, 0);
        cmp_log("R8 fatal run order");
    endtask

    task automatic t_collide();
        int cyc;
        run_pass(16'h0003, 0, 8'd4, 8'd4, 1, 0, 1, cyc);
        build_exp(16'h0003, 1);
        cmp_log("R10 R9 stray acks and start during window");
        chk(win_min == WAITC && win_max == WAITC, "R10 window unaffected by stray acks",
            win_min, WAITC);
        chk(busy_gap == 0, "R9 busy held with start while busy", busy_gap, 0);
        repeat (4) @(negedge clk);
        chk(busy_o == 0, "R9 no restart after ignored start", int'(busy_o), 0);
    endtask

    initial begin
        t_reset();
        t_full_population();
        t_sparse();
        t_pass2();
        t_fatal();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule